// File: doc/BRIEF.md
# Predecoded Partial-Match String Matcher

This block searches a continuous byte stream for a set of byte strings that is fixed when the design is built. It takes in one byte per clock and raises one flag per string. Each incoming byte is compared exactly once against every distinct symbol of a build-time alphabet. The result is a set of one-hot equality lines, one per symbol. Strings do not keep windows of past bytes. Instead, the single-bit equality lines pass through short shift registers. Each string's detector is an AND of the delayed lines it needs, so a symbol's comparator and its delay line are shared by every string that uses that symbol.

Strings longer than sixteen symbols are cut into consecutive pieces of at most sixteen. The hit bit of one piece is delayed by the length of the following piece and becomes an extra input to that piece's AND. As a result, no symbol line is ever delayed by more than fifteen accepted bytes. Stalls on the input (valid low) freeze every delay line, so a string may arrive with gaps.

The string set is supplied as three parameters:
- a packed list of strings, each padded to `MAX_LEN` bytes and written first-to-last from the most significant end;
- a packed list of lengths;
- the alphabet.

Top module: `pmatch_top`

## Requirements
- R1: A byte that is not in the alphabet takes part in no string; a string interrupted by such a byte (for example "ABZCA" in place of "ABCA") raises no flag.
- R2: `match_o[p]` is high in exactly the cycle after the accepted byte (in_valid high) that completes string p, where bit p corresponds to the p-th string of `PATTERNS` counted from its most significant end. With the default set, bit 0 is "ABCA", bit 1 is "ABAB", bit 2 is "AAA" and bit 3 is "ABCDEFGHIJKLMNOPQRST". The latency is the same for every string.
- R3: A string longer than 16 symbols is detected through chained pieces. The flag rises only when all of its symbols have arrived in order; its tail alone, or a stream with a wrong symbol in the first piece, gives no flag.
- R4: Overlapping occurrences are all reported. "ABABAB" flags "ABAB" twice, "AAAAA" flags "AAA" three times, and "ABCABCA" flags "ABCA" twice.
- R5: A cycle with in_valid low is ignored by the delay lines: the byte on `in_byte` is not recorded, the partial state is kept, and `match_o` is all zero in the following cycle.
- R6: A synchronous active-low reset clears all delay state and the flags. No flag can be raised for a string until at least that string's length of bytes has been accepted after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| match_o | output | NUM_PAT | Per-string hit flags, registered |

## Verification
On every cycle the assertions check the following:
- the alphabet decoder lights at most one line;
- a stalled cycle freezes the symbol history and the piece links, and yields an all-zero flag vector;
- any raised flag follows an accepted byte equal to that string's final symbol;
- no flag rises before enough bytes have been accepted since reset.

The directed scenarios are needed for the rest. They show that flags appear for the right strings in the right cycle, and that overlapping repeats each fire. They show that a long string needs its first piece to have hit, and that foreign bytes, stalls and a reset in the middle of a string change the outcome exactly as required.

// File: rtl/pmatch_pkg.sv
// Package: constants shared by the string matcher modules.
// Assumes no string is longer than 255 symbols (lengths are byte-wide).
package pmatch_pkg;
    // Longest piece a single AND tree covers
    localparam int SUB_MAX = 16;
    // Deepest delay a symbol line needs
    localparam int SYM_DLY = SUB_MAX - 1;
endpackage

// File: rtl/sym_decoder.sv
// Module: sym_decoder
// Compares the incoming byte against each alphabet symbol once and gives one
// equality line per symbol. Assumes the alphabet holds distinct bytes,
// listed first-to-last from the most significant end.
module sym_decoder #(
    parameter int NUM_SYM = 20,
    parameter logic [NUM_SYM*8-1:0] ALPHABET = "ABCDEFGHIJKLMNOPQRST"
) (
    input  logic [7:0]         in_byte,
    output logic [NUM_SYM-1:0] dec
);
    for (genvar j = 0; j < NUM_SYM; j++) begin : g_sym
        // one comparator per distinct symbol
        assign dec[j] = (in_byte == ALPHABET[(NUM_SYM-1-j)*8 +: 8]);
    end
endmodule

// File: rtl/sym_history.sv
// Module: sym_history
// Keeps the last DLY decoded lines of every symbol in 1-bit shift registers
// that advance only on accepted bytes. taps[j][k] is symbol j's line for the
// byte accepted k bytes before the current one; tap 0 is the current byte.
module sym_history #(
    parameter int NUM_SYM = 20,
    parameter int DLY     = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [NUM_SYM-1:0] dec,
    output logic [DLY:0]       taps [NUM_SYM]
);
    logic [DLY-1:0] hist [NUM_SYM];

    for (genvar j = 0; j < NUM_SYM; j++) begin : g_line
        // shift this symbol's line on each accepted byte, clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                hist[j] <= '0;
            else if (in_valid)
                hist[j] <= {hist[j][DLY-2:0], dec[j]};
        end

        // expose the current line plus its delayed copies
        assign taps[j] = {hist[j], dec[j]};

        // R5
        hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(hist[j]));
    end

    // R1
    dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $onehot0(dec));
endmodule

// File: rtl/chain_delay.sv
// Module: chain_delay
// Delays a piece's hit bit by DEPTH accepted bytes so that it meets the last
// symbol of the following piece. Advances only when en is high.
module chain_delay #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] sr;

    if (DEPTH == 1) begin : g_one
        // single stage link
        always_ff @(posedge clk) begin
            if (!rst_n)  sr <= '0;
            else if (en) sr <= d;
        end
    end else begin : g_many
        // multi-stage link
        always_ff @(posedge clk) begin
            if (!rst_n)  sr <= '0;
            else if (en) sr <= {sr[DEPTH-2:0], d};
        end
    end

    assign q = sr[DEPTH-1];

    // R5
    link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));
    // R3
    link_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(en));
endmodule

// File: rtl/pmatch_top.sv
// Module: pmatch_top
// Multi-string matcher for a byte stream, one byte per cycle. Strings,
// lengths and alphabet are build-time parameters. String p occupies bytes
// p*MAX_LEN .. p*MAX_LEN+MAX_LEN-1 of PATTERNS counted from the most
// significant end, first symbol first. Assumes every string symbol is in
// ALPHABET, each length is in 1..MAX_LEN, and the alphabet has no repeats.
// match_o[p] is registered: it rises the cycle after the completing byte.
module pmatch_top
    import pmatch_pkg::*;
#(
    parameter int NUM_PAT = 4,
    parameter int MAX_LEN = 20,
    parameter int NUM_SYM = 20,
    parameter logic [NUM_PAT*MAX_LEN*8-1:0] PATTERNS =
        {"ABCA", 128'h0, "ABAB", 128'h0, "AAA", 136'h0,
         "ABCDEFGHIJKLMNOPQRST"},
    parameter logic [NUM_PAT*8-1:0] PAT_LENS = {8'd4, 8'd4, 8'd3, 8'd20},
    parameter logic [NUM_SYM*8-1:0] ALPHABET = "ABCDEFGHIJKLMNOPQRST"
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    output logic [NUM_PAT-1:0] match_o
);
    localparam int CW = $clog2(MAX_LEN + 1);

    // symbol i of string p
    function automatic logic [7:0] pat_char(int p, int i);
        return PATTERNS[(NUM_PAT*MAX_LEN-1-(p*MAX_LEN+i))*8 +: 8];
    endfunction

    // length of string p
    function automatic int pat_len(int p);
        return int'(PAT_LENS[(NUM_PAT-1-p)*8 +: 8]);
    endfunction

    // alphabet index of a byte, -1 when absent
    function automatic int sym_of(logic [7:0] c);
        int r;
        r = -1;
        for (int j = 0; j < NUM_SYM; j++)
            if (r < 0 && ALPHABET[(NUM_SYM-1-j)*8 +: 8] == c) r = j;
        return r;
    endfunction

    logic [NUM_SYM-1:0] dec;
    logic [SYM_DLY:0]   taps [NUM_SYM];
    logic [NUM_PAT-1:0] hit;

    sym_decoder #(.NUM_SYM(NUM_SYM), .ALPHABET(ALPHABET)) u_dec (
        .in_byte (in_byte),
        .dec     (dec)
    );

    sym_history #(.NUM_SYM(NUM_SYM), .DLY(SYM_DLY)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .dec      (dec),
        .taps     (taps)
    );

    for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
        localparam int LEN  = pat_len(p);
        localparam int NSUB = (LEN + SUB_MAX - 1) / SUB_MAX;

        logic [NSUB-1:0] sub_hit;
        logic [NSUB-1:0] link_q;

        assign link_q[0] = 1'b1;

        for (genvar s = 0; s < NSUB; s++) begin : g_sub
            localparam int BASE = s * SUB_MAX;
            localparam int SLEN = (LEN - BASE < SUB_MAX) ? LEN - BASE : SUB_MAX;

            logic [SLEN-1:0] terms;

            for (genvar j = 0; j < SLEN; j++) begin : g_chr
                localparam int SYM = sym_of(pat_char(p, BASE + j));
                localparam int D   = SLEN - 1 - j;
                if (SYM >= 0) begin : g_ok
                    // pick this symbol's line delayed to align with the piece end
                    assign terms[j] = taps[SYM][D];
                end else begin : g_none
                    // symbol outside the alphabet can never be seen
                    assign terms[j] = 1'b0;
                end
            end

            // AND tree of the piece, gated by the previous piece's delayed hit
            assign sub_hit[s] = (&terms) & link_q[s];

            if (s < NSUB - 1) begin : g_link
                localparam int NLEN = (LEN - BASE - SUB_MAX < SUB_MAX) ?
                                      LEN - BASE - SUB_MAX : SUB_MAX;
                chain_delay #(.DEPTH(NLEN)) u_link (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .en    (in_valid),
                    .d     (sub_hit[s]),
                    .q     (link_q[s+1])
                );
            end
        end

        assign hit[p] = sub_hit[NSUB-1];
    end

    // register the flags, forcing zero on stalled cycles
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_o <= '0;
        else
            match_o <= in_valid ? hit : '0;
    end

    // ---------------- checks ----------------
    logic [CW-1:0] acc_cnt;

    // accepted bytes since reset, saturating (used by the checks only)
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_cnt <= '0;
        else if (in_valid && acc_cnt != CW'(MAX_LEN))
            acc_cnt <= acc_cnt + 1'b1;
    end

    // R5
    stall_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (match_o == '0));

    for (genvar p = 0; p < NUM_PAT; p++) begin : g_chk
        localparam int LEN = pat_len(p);
        localparam logic [7:0] LAST = pat_char(p, LEN - 1);
        // R2
        last_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[p] |-> ($past(in_valid) && $past(in_byte) == LAST));
        // R6
        enough_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[p] |-> (int'(acc_cnt) >= LEN));
    end
endmodule

// File: tb/tb_pmatch_top.sv
module tb_pmatch_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic [NP-1:0] match_o;

    int tests = 0;
    int fails = 0;

    string pats [NP] = '{"ABCA", "ABAB", "AAA", "ABCDEFGHIJKLMNOPQRST"};
    logic [7:0] hist [64];
    int acc = 0;

    pmatch_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .match_o  (match_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference: string p matches when its symbols are the newest accepted bytes
    function automatic logic [NP-1:0] ref_match();
        logic [NP-1:0] r;
        r = '0;
        for (int p = 0; p < NP; p++) begin
            int L;
            logic ok;
            L = pats[p].len();
            ok = (acc >= L);
            for (int i = 0; i < L; i++)
                if (hist[L-1-i] != pats[p][i]) ok = 1'b0;
            r[p] = ok;
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: match_o=%b expected %b", tag, act, exp);
        end
    endtask

    // drive one byte, update the model, compare the flags of that byte
    task automatic send(logic [7:0] b, logic v, string tag);
        logic [NP-1:0] e;
        @(negedge clk);
        in_byte  = b;
        in_valid = v;
        @(posedge clk);
        if (v) begin
            for (int k = 63; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = b;
            acc++;
        end
        e = v ? ref_match() : '0;
        #1;
        chk(tag, match_o, e);
    endtask

    task automatic send_str(string s, string tag);
        for (int i = 0; i < s.len(); i++) send(s[i], 1'b1, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        for (int k = 0; k < 64; k++) hist[k] = 8'h00;
        acc = 0;
        #1;
        chk("R6 reset", match_o, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        send_str("ABC", "R2");
        send("A", 1'b1, "R2");
        chk("R2 ABCA flag", match_o, 4'b0001);
        send_str("XXAB", "R2");
        send_str("CA", "R2");
        chk("R2 second ABCA", match_o, 4'b0001);
    endtask

    task automatic t_overlap();
        do_reset();
        send_str("ABABA", "R4");
        send("B", 1'b1, "R4");
        chk("R4 ABAB repeat", match_o, 4'b0010);
        send("Q", 1'b1, "R4");
        send_str("AAAA", "R4");
        send("A", 1'b1, "R4");
        chk("R4 AAA repeat", match_o, 4'b0100);
        send_str("ABCABC", "R4");
        send("A", 1'b1, "R4");
        chk("R4 ABCA overlap", match_o, 4'b0001);
    endtask

    task automatic t_long();
        do_reset();
        send_str("ABCDEFGHIJKLMNOPQRS", "R3");
        send("T", 1'b1, "R3");
        chk("R3 long hit", match_o, 4'b1000);
        send_str("ABCDEFGHIJKLMXOPQRST", "R3");
        chk("R3 first piece broken", match_o, 4'b0000);
        send_str("QRST", "R3");
        chk("R3 tail only", match_o, 4'b0000);
    endtask

    task automatic t_foreign();
        do_reset();
        send_str("ABZCA", "R1");
        chk("R1 foreign byte", match_o, 4'b0000);
        send_str("AA", "R1");
        send(8'h00, 1'b1, "R1");
        send("A", 1'b1, "R1");
        chk("R1 null byte", match_o, 4'b0000);
    endtask

    task automatic t_stall();
        do_reset();
        send_str("ABC", "R5");
        send("A", 1'b0, "R5 stalled A");
        chk("R5 stall output", match_o, 4'b0000);
        send("Z", 1'b0, "R5");
        send("A", 1'b1, "R5");
        chk("R5 hit after stall", match_o, 4'b0001);
        send_str("AA", "R5");
        send("B", 1'b0, "R5");
        send("A", 1'b1, "R5");
        chk("R5 AAA through gap", match_o, 4'b0100);
    endtask

    task automatic t_reset_mid();
        send_str("ABC", "R6");
        do_reset();
        send("A", 1'b1, "R6");
        chk("R6 split by reset", match_o, 4'b0000);
        send_str("ABCDEFGHIJ", "R6");
        do_reset();
        send_str("KLMNOPQRST", "R6");
        chk("R6 long split by reset", match_o, 4'b0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        t_basic();
        t_overlap();
        t_long();
        t_foreign();
        t_stall();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule